// File: doc/BRIEF.md
# Serial Dual-Channel DAC Command Receiver

This block is the digital front end of a two-channel 10-bit voltage DAC, running entirely in the system clock domain. It oversamples a three-wire serial bus: an active-low select, a serial clock and a data line. It collects a 16-bit command word and decodes it into a channel A register, a channel B register, a shared staging register, a power-down flag and a settling-speed flag. The analog side reads `chan_a`, `chan_b`, `pwr_down` and `fast_mode` directly.

A frame opens when the select goes low. Bits enter on each falling edge of the serial clock, most significant first. On the sixteenth falling edge the word is committed at once and the receiver locks, ignoring any further clocks until the select goes high again. A frame that closes early is thrown away. The staging register lets a host stage a value for channel B and then move both channels in the same cycle with one channel A write.

An internal power-on reset, stretched for a few cycles after the external reset input, forces every register into its default state.

Top module: `dac_cmd_rx`

## Requirements
- R1: During reset and its stretch period, and after it, before any frame: `chan_a` = 0, `chan_b` = 0, `pwr_down` = 0, `fast_mode` = 0, `upd_stb` = 0. The staging register also clears to 0.
- R2: Word bits are taken on serial-clock falling edges while select is low, first bit as bit 15 down to bit 0. The 10-bit channel value is word bits 11..2. Word bits 1..0 have no effect.
- R3: When word bit 15 = 1, `chan_a` takes the channel value and `chan_b` takes the staging register, both in the same cycle. The staging register is unchanged.
- R4: When word bit 15 = 0 and bit 12 = 1, only the staging register takes the channel value. `chan_a` and `chan_b` are unchanged.
- R5: When word bit 15 = 0 and bit 12 = 0, `chan_b` takes the channel value. `chan_a` and the staging register are unchanged.
- R6: On every commit, `pwr_down` becomes the inverse of word bit 13 (bit 13 = 0 means power down).
- R7: On every commit, `fast_mode` becomes word bit 14 (1 = fast settling, 0 = slow).
- R8: The word commits on the 16th falling edge after select goes low. Later falling edges in the same frame change nothing and cause no further strobe.
- R9: If select goes high before 16 falling edges, no register changes and no strobe is raised.
- R10: `upd_stb` is high for exactly one cycle per commit. The outputs change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, stretched internally |
| ser_csn | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial bit clock, sampled on its falling edge |
| ser_din | input | 1 | Serial data, first bit is word bit 15 |
| chan_a | output | 10 | Channel A value |
| chan_b | output | 10 | Channel B value |
| pwr_down | output | 1 | 1 = converter powered down |
| fast_mode | output | 1 | 1 = fast settling mode |
| upd_stb | output | 1 | One-cycle pulse when a word is applied |

## Verification
The main function is driven with words for each of the three write routes. Their data fields use non-zero low bits, alternating bits and all ones, which separate a correct bit order and field slice from shifted or reversed ones. A staged value written before a channel A write must appear on `chan_b` together with the new `chan_a`; this tells the simultaneous update apart from independent writes. Frames cut short at 9 and at 15 bits, and a 20-bit frame, separate correct counting, discard and lockout from off-by-one counting. A reset in mid-run confirms that the defaults come back.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int WORD_W   = 16;
  localparam int DATA_W   = 12;
  localparam int CH_W     = 10;
  localparam int BIT_SEL  = 15;  // 1: channel A (+ B from staging)
  localparam int BIT_FAST = 14;
  localparam int BIT_PWR  = 13;  // 0: power down
  localparam int BIT_STG  = 12;  // with BIT_SEL=0: 1 staging, 0 channel B

  typedef enum logic [1:0] {
    ROUTE_A_AND_B = 2'd0,
    ROUTE_STAGE   = 2'd1,
    ROUTE_B_ONLY  = 2'd2
  } route_e;

  typedef struct packed {
    route_e            route;
    logic              fast;
    logic              pdn;
    logic [CH_W-1:0]   value;
  } cmd_t;

  function automatic cmd_t split_word(input logic [WORD_W-1:0] w);
    cmd_t c;
    if (w[BIT_SEL])      c.route = ROUTE_A_AND_B;
    else if (w[BIT_STG]) c.route = ROUTE_STAGE;
    else                 c.route = ROUTE_B_ONLY;
    c.fast  = w[BIT_FAST];
    c.pdn   = ~w[BIT_PWR];
    c.value = w[DATA_W-1 -: CH_W];
    return c;
  endfunction
endpackage

// File: rtl/dac_por.sv
module dac_por #(
  parameter int POR_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  output logic rst_int
);
  localparam int CW = (POR_LEN > 1) ? $clog2(POR_LEN) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_int <= 1'b1;
    end else if (cnt != CW'(POR_LEN - 1)) begin
      cnt     <= cnt + 1'b1;
      rst_int <= 1'b1;
    end else begin
      rst_int <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE[i]}};
        else     chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dac_frame.sv
module dac_frame
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              commit_vld,
  output logic [WORD_W-1:0] commit_word,
  output logic              locked,
  output logic [$clog2(WORD_W+1)-1:0] bit_cnt
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              sclk_d;
  logic              fall;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shnext;

  assign fall   = sclk_d & ~sclk_s;
  assign shnext = {shreg[WORD_W-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      shreg       <= '0;
      bit_cnt     <= '0;
      locked      <= 1'b0;
      commit_vld  <= 1'b0;
      commit_word <= '0;
    end else begin
      sclk_d     <= sclk_s;
      commit_vld <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
        locked  <= 1'b0;
      end else if (fall && !locked) begin
        shreg <= shnext;
        if (bit_cnt == CW'(WORD_W - 1)) begin
          commit_vld  <= 1'b1;
          commit_word <= shnext;
          locked      <= 1'b1;
          bit_cnt     <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_vld,
  input  logic [WORD_W-1:0] commit_word,
  output logic [CH_W-1:0]   chan_a,
  output logic [CH_W-1:0]   chan_b,
  output logic [CH_W-1:0]   stage_q,
  output logic              pwr_down,
  output logic              fast_mode,
  output logic              upd_stb
);
  cmd_t cmd;
  assign cmd = split_word(commit_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_a    <= '0;
      chan_b    <= '0;
      stage_q   <= '0;
      pwr_down  <= 1'b0;
      fast_mode <= 1'b0;
      upd_stb   <= 1'b0;
    end else begin
      upd_stb <= commit_vld;
      if (commit_vld) begin
        pwr_down  <= cmd.pdn;
        fast_mode <= cmd.fast;
        case (cmd.route)
          ROUTE_A_AND_B: begin
            chan_a <= cmd.value;
            chan_b <= stage_q;
          end
          ROUTE_STAGE:  stage_q <= cmd.value;
          default:      chan_b  <= cmd.value;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int POR_LEN     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_csn,
  input  logic       ser_clk,
  input  logic       ser_din,
  output logic [9:0] chan_a,
  output logic [9:0] chan_b,
  output logic       pwr_down,
  output logic       fast_mode,
  output logic       upd_stb
);
  import dac_cmd_pkg::*;

  logic                       rst_int;
  logic [2:0]                 sync_q;
  logic                       csn_s, sclk_s, din_s;
  logic                       commit_vld;
  logic [WORD_W-1:0]          commit_word;
  logic                       locked;
  logic [$clog2(WORD_W+1)-1:0] bit_cnt;
  logic [CH_W-1:0]            stage_q;

  dac_por #(.POR_LEN(POR_LEN)) u_por (
    .clk(clk), .rst(rst), .rst_int(rst_int)
  );

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst(rst_int),
    .d({ser_csn, ser_clk, ser_din}),
    .q(sync_q)
  );
  assign csn_s  = sync_q[2];
  assign sclk_s = sync_q[1];
  assign din_s  = sync_q[0];

  dac_frame u_frame (
    .clk(clk), .rst(rst_int),
    .csn_s(csn_s), .sclk_s(sclk_s), .din_s(din_s),
    .commit_vld(commit_vld), .commit_word(commit_word),
    .locked(locked), .bit_cnt(bit_cnt)
  );

  dac_regs u_regs (
    .clk(clk), .rst(rst_int),
    .commit_vld(commit_vld), .commit_word(commit_word),
    .chan_a(chan_a), .chan_b(chan_b), .stage_q(stage_q),
    .pwr_down(pwr_down), .fast_mode(fast_mode), .upd_stb(upd_stb)
  );
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk (
  input logic       clk,
  input logic       rst_int,
  input logic       csn_s,
  input logic       commit_vld,
  input logic [15:0] commit_word,
  input logic       locked,
  input logic [4:0] bit_cnt,
  input logic [9:0] chan_a,
  input logic [9:0] chan_b,
  input logic       pwr_down,
  input logic       fast_mode,
  input logic       upd_stb
);
  p_reset_r1: assert property (@(posedge clk)
    rst_int |=> (chan_a == '0 && chan_b == '0 && !upd_stb && !pwr_down));

  p_count_range_r2: assert property (@(posedge clk) disable iff (rst_int)
    bit_cnt < 5'd16);

  p_lockout_r8: assert property (@(posedge clk) disable iff (rst_int)
    locked |=> !commit_vld);

  p_abort_r9: assert property (@(posedge clk) disable iff (rst_int)
    ($rose(csn_s) && bit_cnt != '0) |=> !commit_vld);

  p_pwr_r6: assert property (@(posedge clk) disable iff (rst_int)
    upd_stb |-> (pwr_down == !$past(commit_word[13])));

  p_fast_r7: assert property (@(posedge clk) disable iff (rst_int)
    upd_stb |-> (fast_mode == $past(commit_word[14])));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst_int)
    upd_stb |=> !upd_stb);

  p_a_quiet_r10: assert property (@(posedge clk) disable iff (rst_int)
    !$stable(chan_a) |-> upd_stb);

  p_b_quiet_r10: assert property (@(posedge clk) disable iff (rst_int)
    !$stable(chan_b) |-> upd_stb);
endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
  .clk(clk), .rst_int(rst_int), .csn_s(csn_s),
  .commit_vld(commit_vld), .commit_word(commit_word),
  .locked(locked), .bit_cnt(bit_cnt),
  .chan_a(chan_a), .chan_b(chan_b),
  .pwr_down(pwr_down), .fast_mode(fast_mode), .upd_stb(upd_stb)
);

// File: tb/dac_cmd_rx_test.sv
module dac_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_csn = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic [9:0] chan_a, chan_b;
  logic       pwr_down, fast_mode, upd_stb;

  always #5 clk = ~clk;

  dac_cmd_rx uut (
    .clk(clk), .rst(rst), .ser_csn(ser_csn), .ser_clk(ser_clk),
    .ser_din(ser_din), .chan_a(chan_a), .chan_b(chan_b),
    .pwr_down(pwr_down), .fast_mode(fast_mode), .upd_stb(upd_stb)
  );

  typedef struct {
    logic [9:0] a;
    logic [9:0] b;
    logic       pd;
    logic       fast;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic [9:0] m_a = '0, m_b = '0, m_stg = '0;
  logic m_pd = 1'b0, m_fast = 1'b0;
  logic prev_stb = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (!done) begin
      if (upd_stb) begin
        check("R10 single-cycle strobe", {31'd0, prev_stb}, 32'd0);
        if (exp_q.size() == 0) begin
          check("R9/R8 unexpected strobe", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " chan_a"},    {22'd0, chan_a},   {22'd0, e.a});
          check({e.tag, " chan_b"},    {22'd0, chan_b},   {22'd0, e.b});
          check({e.tag, " pwr_down"},  {31'd0, pwr_down}, {31'd0, e.pd});
          check({e.tag, " fast_mode"}, {31'd0, fast_mode},{31'd0, e.fast});
        end
      end
      prev_stb <= upd_stb;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // send nbits from bits[31] downward; model updates if nbits >= 16
  task automatic send(input logic [31:0] bits, input int nbits, input string tag);
    logic [15:0] w;
    logic [9:0]  v;
    exp_t e;
    w = bits[31:16];
    v = w[11:2];
    if (nbits >= 16) begin
      m_pd   = ~w[13];
      m_fast = w[14];
      if (w[15]) begin
        m_b = m_stg;
        m_a = v;
      end else if (w[12]) begin
        m_stg = v;
      end else begin
        m_b = v;
      end
      e.a = m_a; e.b = m_b; e.pd = m_pd; e.fast = m_fast; e.tag = tag;
      exp_q.push_back(e);
    end
    ser_csn = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      ser_din = bits[31-i];
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
    wait_clk(4);
    ser_csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_state(input string tag);
    check({tag, " chan_a"},   {22'd0, chan_a},   {22'd0, m_a});
    check({tag, " chan_b"},   {22'd0, chan_b},   {22'd0, m_b});
    check({tag, " pwr_down"}, {31'd0, pwr_down}, {31'd0, m_pd});
    check({tag, " fast"},     {31'd0, fast_mode},{31'd0, m_fast});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    check("R1 strobe during stretch", {31'd0, upd_stb}, 32'd0);
    wait_clk(6);
    check_state("R1 reset defaults");

    // R2 R3 R6 R7: A write, low bits 11 ignored, fast, normal
    send({16'hEABF, 16'h0}, 16, "R2 R3 R7 a-write");
    // R4: staging only
    send({16'h35A4, 16'h0}, 16, "R4 stage-write");
    check_state("R4 outputs unchanged");
    // R3: A and B move together
    send({16'hA004, 16'h0}, 16, "R3 simultaneous");
    // R5 R6: B only, power down, fast
    send({16'h4FFF, 16'h0}, 16, "R5 R6 b-write pdn");
    // R9: abort after 9 bits
    send({32'hFFFF_FFFF}, 9, "R9 abort 9");
    check_state("R9 after 9-bit abort");
    // R8: 20 bits, last 4 ignored
    send({16'hA3FC, 4'hF, 12'h0}, 20, "R8 overlong");
    // R5: B to zero, power down
    send({16'h0000, 16'h0}, 16, "R5 b-zero");
    // R9: abort at 15 bits
    send({16'h8FFC, 16'h0}, 15, "R9 abort 15");
    check_state("R9 after 15-bit abort");
    // R2: alternating pattern
    send({16'hAAAA, 16'h0}, 16, "R2 alternating");

    // R1: reset mid-run
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    m_a = '0; m_b = '0; m_stg = '0; m_pd = 1'b0; m_fast = 1'b0;
    wait_clk(8);
    check_state("R1 reset again");
    send({16'h8000, 16'h0}, 16, "R1 R3 staging cleared");

    wait_clk(10);
    check("R10 all strobes seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule